// File: doc/BRIEF.md
# Switch-Adjusted RGB Gain Stage

This block scales the three 8-bit colour components of a pixel stream. Each component has its own gain held in a register. The gain is an unsigned fixed-point value with one integer bit and eight fraction bits, so it can represent values from 0 to just under 2. The block multiplies each component by its gain and outputs the integer part of the product as the new 8-bit component. The horizontal sync, vertical sync and data-enable flags pass through the same single register stage as the data, so they stay aligned with their pixel.

The gains are set at run time from front-panel style inputs, without any processor access:

- A three-bit channel mask chooses which gains move.
- A direction switch chooses whether they move up or down.
- A group switch says whether the panel is currently driving this block or some other adjustment block.
- A push-button input, already debounced upstream, is synchronised inside the block. Each rising edge of the button moves every selected gain by one LSB.

Every gain starts at unity after reset. A gain can never go above unity or below zero.

Top module: `pix_gain_adj`

## Requirements
- R1: While `rst` is high and in the first cycle after it, all outputs are 0. After reset every gain is unity (9'h100), so a component of 255 comes out as 255.
- R2: Each output component equals bits [15:8] of the 18-bit product of the zero-extended input component and that channel's gain. It appears one clock after the input is sampled.
- R3: A gain never exceeds unity. A step up on a gain already at 9'h100 leaves it unchanged.
- R4: A gain never wraps below zero. A step down on a gain of 0 leaves it at 0.
- R5: Each accepted step changes a gain by exactly 1/256. `dir_down`=1 decrements and `dir_down`=0 increments.
- R6: A step changes only the channels whose `sel_mask` bit is 1: bit 0 is red, bit 1 is green, bit 2 is blue.
- R7: When `grp_gain` is 0, steps have no effect on any gain.
- R8: One rise of `step_btn` gives exactly one step, however long the button is held. A rise first sampled at clock edge k affects pixels sampled at edge k+3 and later. Pixels sampled at edges up to k+2 still use the old gain.
- R9: `out_hs`, `out_vs` and `out_de` equal `in_hs`, `in_vs` and `in_de` delayed by one clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous active-high reset |
| in_r | input | 8 | Red component in |
| in_g | input | 8 | Green component in |
| in_b | input | 8 | Blue component in |
| in_hs | input | 1 | Horizontal sync in |
| in_vs | input | 1 | Vertical sync in |
| in_de | input | 1 | Data enable in |
| sel_mask | input | 3 | Channel select for steps (bit0 R, bit1 G, bit2 B) |
| dir_down | input | 1 | 1 = step down, 0 = step up |
| grp_gain | input | 1 | 1 = the adjustment panel drives this block |
| step_btn | input | 1 | Debounced step button level (asynchronous) |
| out_r | output | 8 | Scaled red component |
| out_g | output | 8 | Scaled green component |
| out_b | output | 8 | Scaled blue component |
| out_hs | output | 1 | Delayed horizontal sync |
| out_vs | output | 1 | Delayed vertical sync |
| out_de | output | 1 | Delayed data enable |

## Verification
A gain step and a multiply can land in the same clock edge: the gain register updates at the same edge that samples a pixel. To provoke this, the bench streams a new pixel every cycle and raises the step button together with one of those pixels. The scoreboard expects the old gain on the first three pixels of the run and the new gain from the fourth pixel on. It also expects each selected channel to move by exactly one LSB, and the unselected channel to keep its gain.

// File: rtl/pix_gain_pkg.sv
package pix_gain_pkg;
  // number of colour channels handled side by side
  localparam int unsigned NCH = 3;

  // video timing flags carried beside the data
  typedef struct packed {
    logic hs;
    logic vs;
    logic de;
  } sync_t;
endpackage

// File: rtl/pix_gain_step_sync.sv
// Brings the asynchronous button level into the clock domain and emits a
// one-cycle pulse on each rising edge.
module pix_gain_step_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic btn_i,
  output logic pulse_o
);
  logic [STAGES-1:0] sr_q;
  logic              prev_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      sr_q   <= '0;
      prev_q <= 1'b0;
    end else begin
      sr_q   <= {sr_q[STAGES-2:0], btn_i};
      prev_q <= sr_q[STAGES-1];
    end
  end

  assign pulse_o = sr_q[STAGES-1] & ~prev_q;
endmodule

// File: rtl/pix_gain_reg.sv
// One channel gain: 1.FRAC_W fixed point, unity at reset, saturating steps.
module pix_gain_reg #(
  parameter int unsigned FRAC_W = 8,
  localparam int unsigned GAIN_W = FRAC_W + 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              step_i,
  input  logic              enable_i,
  input  logic              down_i,
  output logic [GAIN_W-1:0] gain_o
);
  localparam logic [GAIN_W-1:0] UNITY = {1'b1, {FRAC_W{1'b0}}};

  logic [GAIN_W-1:0] gain_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      gain_q <= UNITY;
    end else if (step_i && enable_i) begin
      if (down_i) begin
        if (gain_q != '0) gain_q <= gain_q - 1'b1;
      end else begin
        if (gain_q < UNITY) gain_q <= gain_q + 1'b1;
      end
    end
  end

  assign gain_o = gain_q;
endmodule

// File: rtl/pix_gain_mul.sv
// Registered multiply of one component by its gain; keeps the integer byte.
module pix_gain_mul #(
  parameter int unsigned PIX_W  = 8,
  parameter int unsigned FRAC_W = 8,
  localparam int unsigned GAIN_W = FRAC_W + 1,
  localparam int unsigned PROD_W = 2 * ((PIX_W + 1 > GAIN_W) ? PIX_W + 1 : GAIN_W)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [PIX_W-1:0]  pix_i,
  input  logic [GAIN_W-1:0] gain_i,
  output logic [PIX_W-1:0]  pix_o
);
  logic [PROD_W-1:0] a_ext;
  logic [PROD_W-1:0] b_ext;
  logic [PROD_W-1:0] prod;

  always_comb begin
    a_ext = PROD_W'(pix_i);
    b_ext = PROD_W'(gain_i);
    prod  = a_ext * b_ext;
  end

  always_ff @(posedge clk) begin
    if (rst) pix_o <= '0;
    else     pix_o <= prod[FRAC_W +: PIX_W];
  end
endmodule

// File: rtl/pix_gain_adj.sv
module pix_gain_adj
  import pix_gain_pkg::*;
#(
  parameter int unsigned PIX_W       = 8,
  parameter int unsigned FRAC_W      = 8,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [PIX_W-1:0] in_r,
  input  logic [PIX_W-1:0] in_g,
  input  logic [PIX_W-1:0] in_b,
  input  logic             in_hs,
  input  logic             in_vs,
  input  logic             in_de,
  input  logic [2:0]       sel_mask,
  input  logic             dir_down,
  input  logic             grp_gain,
  input  logic             step_btn,
  output logic [PIX_W-1:0] out_r,
  output logic [PIX_W-1:0] out_g,
  output logic [PIX_W-1:0] out_b,
  output logic             out_hs,
  output logic             out_vs,
  output logic             out_de
);
  localparam int unsigned GAIN_W = FRAC_W + 1;

  logic                          step_pulse;
  logic [NCH-1:0][GAIN_W-1:0]    gain_q;
  logic [NCH-1:0][PIX_W-1:0]     pix_in;
  logic [NCH-1:0][PIX_W-1:0]     pix_out;
  sync_t                         ctl_q;

  assign pix_in[0] = in_r;
  assign pix_in[1] = in_g;
  assign pix_in[2] = in_b;

  pix_gain_step_sync #(.STAGES(SYNC_STAGES)) u_step (
    .clk    (clk),
    .rst    (rst),
    .btn_i  (step_btn),
    .pulse_o(step_pulse)
  );

  for (genvar ch = 0; ch < NCH; ch++) begin : g_ch
    pix_gain_reg #(.FRAC_W(FRAC_W)) u_reg (
      .clk     (clk),
      .rst     (rst),
      .step_i  (step_pulse),
      .enable_i(grp_gain & sel_mask[ch]),
      .down_i  (dir_down),
      .gain_o  (gain_q[ch])
    );

    pix_gain_mul #(.PIX_W(PIX_W), .FRAC_W(FRAC_W)) u_mul (
      .clk   (clk),
      .rst   (rst),
      .pix_i (pix_in[ch]),
      .gain_i(gain_q[ch]),
      .pix_o (pix_out[ch])
    );
  end

  // timing flags get the same single register stage as the products
  always_ff @(posedge clk) begin
    if (rst) ctl_q <= '0;
    else     ctl_q <= '{hs: in_hs, vs: in_vs, de: in_de};
  end

  assign out_r  = pix_out[0];
  assign out_g  = pix_out[1];
  assign out_b  = pix_out[2];
  assign out_hs = ctl_q.hs;
  assign out_vs = ctl_q.vs;
  assign out_de = ctl_q.de;
endmodule

// File: rtl/pix_gain_adj_chk.sv
module pix_gain_adj_chk #(
  parameter int unsigned PIX_W  = 8,
  parameter int unsigned FRAC_W = 8,
  localparam int unsigned GAIN_W = FRAC_W + 1,
  localparam int unsigned NCH    = 3
) (
  input logic                       clk,
  input logic                       rst,
  input logic [PIX_W-1:0]           in_r,
  input logic [PIX_W-1:0]           in_g,
  input logic [PIX_W-1:0]           in_b,
  input logic                       in_hs,
  input logic                       in_vs,
  input logic                       in_de,
  input logic [2:0]                 sel_mask,
  input logic                       dir_down,
  input logic                       grp_gain,
  input logic [PIX_W-1:0]           out_r,
  input logic [PIX_W-1:0]           out_g,
  input logic [PIX_W-1:0]           out_b,
  input logic                       out_hs,
  input logic                       out_vs,
  input logic                       out_de,
  input logic                       step_pulse,
  input logic [NCH-1:0][GAIN_W-1:0] gain_q
);
  localparam logic [GAIN_W-1:0] UNITY = {1'b1, {FRAC_W{1'b0}}};

  logic past_ok;
  always_ff @(posedge clk) begin
    if (rst) past_ok <= 1'b0;
    else     past_ok <= 1'b1;
  end

  p_flags_lat_r9: assert property (@(posedge clk) disable iff (rst)
    past_ok |-> (out_hs == $past(in_hs) && out_vs == $past(in_vs) && out_de == $past(in_de)));

  p_no_gain_up_r2: assert property (@(posedge clk) disable iff (rst)
    past_ok |-> (out_r <= $past(in_r) && out_g <= $past(in_g) && out_b <= $past(in_b)));

  p_group_hold_r7: assert property (@(posedge clk) disable iff (rst)
    !(step_pulse && grp_gain) |=> $stable(gain_q));

  for (genvar i = 0; i < NCH; i++) begin : g_chk
    p_gain_cap_r3: assert property (@(posedge clk) disable iff (rst)
      gain_q[i] <= UNITY);

    p_unsel_hold_r6: assert property (@(posedge clk) disable iff (rst)
      (step_pulse && !sel_mask[i]) |=> $stable(gain_q[i]));

    p_step_up_r5: assert property (@(posedge clk) disable iff (rst)
      (step_pulse && grp_gain && sel_mask[i] && !dir_down && gain_q[i] < UNITY)
        |=> gain_q[i] == GAIN_W'($past(gain_q[i]) + 1'b1));

    p_floor_r4: assert property (@(posedge clk) disable iff (rst)
      (step_pulse && grp_gain && sel_mask[i] && dir_down && gain_q[i] == '0)
        |=> gain_q[i] == '0);
  end
endmodule

bind pix_gain_adj pix_gain_adj_chk #(.PIX_W(PIX_W), .FRAC_W(FRAC_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .in_r      (in_r),
  .in_g      (in_g),
  .in_b      (in_b),
  .in_hs     (in_hs),
  .in_vs     (in_vs),
  .in_de     (in_de),
  .sel_mask  (sel_mask),
  .dir_down  (dir_down),
  .grp_gain  (grp_gain),
  .out_r     (out_r),
  .out_g     (out_g),
  .out_b     (out_b),
  .out_hs    (out_hs),
  .out_vs    (out_vs),
  .out_de    (out_de),
  .step_pulse(step_pulse),
  .gain_q    (gain_q)
);

// File: tb/sim_pix_gain_adj.sv
`timescale 1ns/1ps
module sim_pix_gain_adj;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [7:0] in_r = '0, in_g = '0, in_b = '0;
  logic       in_hs = 1'b0, in_vs = 1'b0, in_de = 1'b0;
  logic [2:0] sel_mask = '0;
  logic       dir_down = 1'b0, grp_gain = 1'b1, step_btn = 1'b0;
  logic [7:0] out_r, out_g, out_b;
  logic       out_hs, out_vs, out_de;

  always #5 clk = ~clk;

  pix_gain_adj u0 (
    .clk(clk), .rst(rst), .in_r(in_r), .in_g(in_g), .in_b(in_b),
    .in_hs(in_hs), .in_vs(in_vs), .in_de(in_de), .sel_mask(sel_mask),
    .dir_down(dir_down), .grp_gain(grp_gain), .step_btn(step_btn),
    .out_r(out_r), .out_g(out_g), .out_b(out_b),
    .out_hs(out_hs), .out_vs(out_vs), .out_de(out_de)
  );

  typedef struct {
    int    r;
    int    g;
    int    b;
    int    ctl;
    string tag;
  } exp_t;

  exp_t q[$];
  int   gm[3];
  int   checks = 0;
  int   failures = 0;
  bit   done = 1'b0;

  // bench model of the gains (R3, R4, R5, R6, R7)
  function automatic void model_step();
    if (!grp_gain) return;
    for (int i = 0; i < 3; i++) begin
      if (sel_mask[i]) begin
        if (dir_down) gm[i] = (gm[i] > 0) ? gm[i] - 1 : 0;
        else          gm[i] = (gm[i] < 256) ? gm[i] + 1 : 256;
      end
    end
  endfunction

  function automatic int scale(int p, int g);
    return ((p * g) >> 8) & 255;
  endfunction

  task automatic drive(input int r, input int g, input int b,
                       input logic hs, input logic vs, input logic de,
                       input string tag);
    exp_t e;
    @(negedge clk);
    in_r = 8'(r); in_g = 8'(g); in_b = 8'(b);
    in_hs = hs; in_vs = vs; in_de = de;
    e.r = scale(r, gm[0]); e.g = scale(g, gm[1]); e.b = scale(b, gm[2]);
    e.ctl = {29'd0, hs, vs, de};
    e.tag = tag;
    q.push_back(e);
  endtask

  task automatic press(input int hold);
    @(negedge clk);
    step_btn = 1'b1;
    repeat (hold) @(negedge clk);
    step_btn = 1'b0;
    model_step();
    repeat (4) @(negedge clk);
  endtask

  // monitor: pops one expected item per clock after the data register updates
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (q.size() > 0) begin
        exp_t e;
        int   act_ctl;
        e = q.pop_front();
        act_ctl = {29'd0, out_hs, out_vs, out_de};
        checks++;
        if (out_r != e.r[7:0] || out_g != e.g[7:0] || out_b != e.b[7:0] || act_ctl != e.ctl) begin
          failures++;
          $display("FAIL %s: got rgb=%0d,%0d,%0d ctl=%0d expected rgb=%0d,%0d,%0d ctl=%0d",
                   e.tag, out_r, out_g, out_b, act_ctl, e.r, e.g, e.b, e.ctl);
        end
      end
    end
  end

  initial begin
    #2_000_000;
    if (!done) begin
      failures++;
      $display("FAIL watchdog: got no finish expected finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 3; i++) gm[i] = 256;
    // R1: outputs held at zero during reset even with active inputs
    in_r = 8'd255; in_g = 8'd255; in_b = 8'd255; in_de = 1'b1; in_hs = 1'b1; in_vs = 1'b1;
    repeat (4) @(negedge clk);
    checks++;
    if (out_r != 0 || out_g != 0 || out_b != 0 || out_de || out_hs || out_vs) begin
      failures++;
      $display("FAIL R1 reset: got rgb=%0d,%0d,%0d expected 0,0,0", out_r, out_g, out_b);
    end
    rst = 1'b0;
    checks++;
    if (out_r != 0 || out_de) begin
      failures++;
      $display("FAIL R1 post-reset: got r=%0d de=%0d expected 0", out_r, out_de);
    end

    drive(255, 255, 255, 1'b0, 1'b0, 1'b1, "R1 unity gain");
    // R2 / R9: varied data and flags at unity
    drive(0, 128, 17, 1'b1, 1'b0, 1'b0, "R2 R9 pattern a");
    drive(200, 1, 99, 1'b0, 1'b1, 1'b1, "R2 R9 pattern b");
    drive(73, 254, 3, 1'b1, 1'b1, 1'b0, "R2 R9 pattern c");

    // R3: step up at unity leaves gains at unity
    sel_mask = 3'b111; dir_down = 1'b0;
    press(4);
    drive(255, 255, 255, 1'b0, 1'b0, 1'b1, "R3 up at unity");

    // R5 R6: step down red only
    sel_mask = 3'b001; dir_down = 1'b1;
    press(4);
    drive(255, 255, 255, 1'b0, 1'b0, 1'b1, "R5 R6 red down one");

    // R7: other group active, green untouched
    grp_gain = 1'b0; sel_mask = 3'b010;
    press(4);
    drive(255, 255, 255, 1'b0, 1'b0, 1'b1, "R7 group off");
    grp_gain = 1'b1;

    // R5: blue down ten steps, several inputs
    sel_mask = 3'b100;
    for (int k = 0; k < 10; k++) press(3);
    drive(255, 200, 255, 1'b0, 1'b0, 1'b1, "R5 blue 10 steps");
    drive(128, 128, 128, 1'b1, 1'b0, 1'b1, "R2 mid values");
    drive(1, 2, 200, 1'b0, 1'b1, 1'b0, "R2 low values");

    // R8: long hold gives a single step on green
    sel_mask = 3'b010;
    press(40);
    drive(255, 255, 255, 1'b0, 1'b0, 1'b1, "R8 long hold one step");

    // R4: red driven to zero and past it
    sel_mask = 3'b001; dir_down = 1'b1;
    for (int k = 0; k < 260; k++) press(3);
    drive(255, 255, 255, 1'b0, 1'b0, 1'b1, "R4 floor at zero");
    dir_down = 1'b0;
    press(3);
    drive(255, 255, 255, 1'b0, 1'b0, 1'b1, "R4 one above floor");
    press(3);
    drive(255, 255, 255, 1'b0, 1'b0, 1'b1, "R4 two above floor");

    // R3: climb all channels well past unity
    sel_mask = 3'b111;
    for (int k = 0; k < 300; k++) press(3);
    drive(255, 255, 255, 1'b0, 1'b0, 1'b1, "R3 clamp at unity");
    drive(100, 50, 25, 1'b1, 1'b1, 1'b1, "R3 unity pass");

    // R8: step and multiply in the same edge during a stream
    sel_mask = 3'b101; dir_down = 1'b1;
    for (int idx = 0; idx < 8; idx++) begin
      if (idx == 3) model_step();
      @(negedge clk);
      if (idx == 0) step_btn = 1'b1;
      begin
        exp_t e;
        in_r = 8'd255; in_g = 8'd255; in_b = 8'd255;
        in_hs = idx[0]; in_vs = 1'b0; in_de = 1'b1;
        e.r = scale(255, gm[0]); e.g = scale(255, gm[1]); e.b = scale(255, gm[2]);
        e.ctl = {29'd0, idx[0], 1'b0, 1'b1};
        e.tag = "R8 stream edge timing";
        q.push_back(e);
      end
    end
    step_btn = 1'b0;
    repeat (5) @(negedge clk);
    drive(255, 255, 255, 1'b0, 1'b0, 1'b0, "R6 R8 after stream");

    repeat (3) @(negedge clk);
    checks++;
    if (q.size() != 0) begin
      failures++;
      $display("FAIL R2 scoreboard drain: got %0d left expected 0", q.size());
    end
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule